// File: doc/BRIEF.md
# DTMF Tone-Pair Frequency Detector

This block sits behind the band-split comparators of a touch-tone receiver. It takes two squared, full-swing 1-bit signals. One comes from the low-frequency band and one from the high-frequency band. For each band it counts system clocks between rising edges to measure the period. It keeps a sliding sum of the last four complete periods. It then classifies that sum against the four standard tones of the band.

When both bands carry a recognised tone, the block raises a signal-condition flag. The flag carries a 2-bit row index for the low band and a 2-bit column index for the high band. Together they cover all sixteen key pairs. A later steering stage uses the flag for duration checks and output latching.

The flag falls as soon as either band loses its tone. A band loses its tone when its averaged period leaves the tolerance band, or when edges stop arriving. A power-down input holds every counter cleared. A band can only return to valid after a fresh set of periods has been measured.

Top module: `dtmf_pair_detector`

## Requirements
- R1: With both inputs toggling at the nominal period round(CLK_HZ/f), the detector raises sig_cond for all sixteen pairs. row_idx is 0,1,2,3 for 697,770,852,941 Hz. col_idx is 0,1,2,3 for 1209,1336,1477,1633 Hz.
- R2: A band is judged on the sum S of its last WIN=4 complete periods. A band that starts from cold (after reset, power-down or timeout) is never valid before WIN periods have been measured.
- R3: A band that is not valid becomes valid with tone k only when 1000*S lies within [980*WIN*nom_k, 1020*WIN*nom_k]. With a steady period P this means 0.98*nom_k <= P <= 1.02*nom_k.
- R4: A band that is valid with tone k stays valid with the same index while 1000*S lies within [965*WIN*nom_k, 1035*WIN*nom_k]. Outside that range it drops, unless it falls inside another tone's accept range.
- R5: If no rising edge arrives within TIMEOUT_CLKS clocks of the previous one, the band becomes invalid and its window is emptied. Every period that is measured is shorter than TIMEOUT_CLKS.
- R6: sig_cond is high only while both bands are valid. A single tone on one band leaves it low. The cycle after either band goes invalid, it is low.
- R7: While pwr_down is high, sig_cond is low from the next cycle on and all measurement state is cleared. After release, reacquisition needs fresh periods.
- R8: After reset, sig_cond, row_idx and col_idx are 0.
- R9: A valid band keeps its index, and stays valid, unless a new period or a timeout has been registered on that band.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the period-counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | Active-high standby; clears all measurement state |
| low_sq | input | 1 | Squared low-band tone |
| high_sq | input | 1 | Squared high-band tone |
| sig_cond | output | 1 | Both bands carry a recognised tone |
| row_idx | output | 2 | Low-band tone index |
| col_idx | output | 2 | High-band tone index |

## Verification
Two functions can fall in the same cycle. One band can register a fresh period while the other band times out. Likewise, the hold decision for the current tone can be taken in the same evaluation where a shifted period would fail the accept test. The first case is provoked by silencing the high band while the low band keeps toggling. It is judged by sig_cond dropping one cycle after the timeout pulse. The second case is provoked by sliding a locked tone to exactly the last period inside the hold band, and then one count past it. The bench judges both cases at the ports against bounds it computes itself from integer arithmetic.

// File: rtl/dtmf_det_pkg.sv
// Shared constants and elaboration-time helpers for the tone-pair detector.
// Assumes tone frequencies are exact integers in Hz and CLK_HZ fits an int.
package dtmf_det_pkg;

    localparam int NUM_TONES = 4;
    localparam int IDX_W     = 2;

    // Tone frequency in Hz for group 0 (low band) or 1 (high band).
    function automatic int tone_hz(input int grp, input int idx);
        int hz;
        if (grp == 0) begin
            case (idx)
                0:       hz = 697;
                1:       hz = 770;
                2:       hz = 852;
                default: hz = 941;
            endcase
        end else begin
            case (idx)
                0:       hz = 1209;
                1:       hz = 1336;
                2:       hz = 1477;
                default: hz = 1633;
            endcase
        end
        return hz;
    endfunction

    // Nominal period in clocks, rounded to nearest.
    function automatic int nominal_clks(input int clk_hz, input int hz);
        return (clk_hz + hz / 2) / hz;
    endfunction

    // Window-sum bound at permille of WIN*nom, rounded inward.
    function automatic int band_edge(input int nom, input int win,
                                     input int permille, input bit round_up);
        longint num;
        num = longint'(nom) * longint'(win) * longint'(permille);
        if (round_up)
            return int'((num + 64'sd999) / 64'sd1000);
        else
            return int'(num / 64'sd1000);
    endfunction

endpackage

// File: rtl/tone_period_meter.sv
// Measures the period of one squared tone by counting clocks between
// synchronised rising edges, and keeps a sliding sum of the last WIN
// periods. A gap of TIMEOUT_CLKS clocks disarms the channel and empties the
// window. Assumes the input is asynchronous, with a period >= 4 clocks.
module tone_period_meter #(
    parameter int TIMEOUT_CLKS = 8192,
    parameter int WIN          = 4,
    parameter int CNT_W        = 14,
    parameter int SUM_W        = 16,
    parameter int FILL_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             sq_in,
    output logic [SUM_W-1:0] win_sum,
    output logic             win_full,
    output logic             upd_p,
    output logic             tmo_p,
    output logic [CNT_W-1:0] last_period
);

    logic [2:0]        sync_q;
    logic              rise;
    logic              armed;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  hist [WIN];
    logic [FILL_W-1:0] fill;

    // Two-flop synchroniser plus previous-sample stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down)
            sync_q <= '0;
        else
            sync_q <= {sync_q[1:0], sq_in};
    end

    assign rise     = sync_q[1] & ~sync_q[2];
    assign win_full = (fill == FILL_W'(WIN));

    // Period counter, sliding window, fill level, timeout and update pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            armed       <= 1'b0;
            cnt         <= '0;
            fill        <= '0;
            win_sum     <= '0;
            upd_p       <= 1'b0;
            tmo_p       <= 1'b0;
            last_period <= '0;
            for (int i = 0; i < WIN; i++) hist[i] <= '0;
        end else begin
            upd_p <= 1'b0;
            tmo_p <= 1'b0;
            if (rise) begin
                cnt   <= CNT_W'(1);
                armed <= 1'b1;
                if (armed) begin
                    hist[0] <= cnt;
                    for (int i = 1; i < WIN; i++) hist[i] <= hist[i-1];
                    win_sum     <= win_sum + SUM_W'(cnt) - SUM_W'(hist[WIN-1]);
                    last_period <= cnt;
                    upd_p       <= 1'b1;
                    if (!win_full) fill <= fill + FILL_W'(1);
                end
            end else if (armed) begin
                if (cnt == CNT_W'(TIMEOUT_CLKS - 1)) begin
                    armed   <= 1'b0;
                    fill    <= '0;
                    win_sum <= '0;
                    tmo_p   <= 1'b1;
                    for (int i = 0; i < WIN; i++) hist[i] <= '0;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/tone_group_classifier.sv
// Classifies the window sum of one band against the four tones of GROUP.
// A tone is acquired inside a +/-2% band. A held tone survives inside
// +/-3.5%. Assumes the bands of neighbouring tones do not overlap.
module tone_group_classifier
    import dtmf_det_pkg::*;
#(
    parameter int CLK_HZ = 3579545,
    parameter int GROUP  = 0,
    parameter int WIN    = 4,
    parameter int SUM_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic [SUM_W-1:0] win_sum,
    input  logic             win_full,
    output logic             tone_valid,
    output logic [IDX_W-1:0] tone_idx
);

    logic [NUM_TONES-1:0] in_acc;
    logic [NUM_TONES-1:0] in_hold;
    logic                 any_acc;
    logic [IDX_W-1:0]     acc_idx;

    // One comparator pair per tone, with bounds fixed at elaboration.
    for (genvar k = 0; k < NUM_TONES; k++) begin : g_tone
        localparam int NOM     = nominal_clks(CLK_HZ, tone_hz(GROUP, k));
        localparam int ACC_LO  = band_edge(NOM, WIN, 980, 1'b1);
        localparam int ACC_HI  = band_edge(NOM, WIN, 1020, 1'b0);
        localparam int HOLD_LO = band_edge(NOM, WIN, 965, 1'b1);
        localparam int HOLD_HI = band_edge(NOM, WIN, 1035, 1'b0);
        assign in_acc[k]  = (win_sum >= SUM_W'(ACC_LO))  && (win_sum <= SUM_W'(ACC_HI));
        assign in_hold[k] = (win_sum >= SUM_W'(HOLD_LO)) && (win_sum <= SUM_W'(HOLD_HI));
    end

    // Lowest-index tone whose accept band contains the sum.
    always_comb begin
        any_acc = 1'b0;
        acc_idx = '0;
        for (int k = NUM_TONES - 1; k >= 0; k--) begin
            if (in_acc[k]) begin
                any_acc = 1'b1;
                acc_idx = IDX_W'(k);
            end
        end
    end

    // Hysteretic valid/index state: hold the current tone, else try to acquire.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            tone_valid <= 1'b0;
            tone_idx   <= '0;
        end else if (!win_full) begin
            tone_valid <= 1'b0;
        end else if (tone_valid && in_hold[tone_idx]) begin
            tone_valid <= 1'b1;
        end else if (any_acc) begin
            tone_valid <= 1'b1;
            tone_idx   <= acc_idx;
        end else begin
            tone_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/dtmf_pair_detector.sv
// Two-band tone-pair detector. One period meter and one classifier per band
// (index 0 = low band, 1 = high band). sig_cond is the AND of both bands'
// valid flags. Assumes CLK_HZ is the clock that drives clk.
module dtmf_pair_detector
    import dtmf_det_pkg::*;
#(
    parameter int CLK_HZ       = 3579545,
    parameter int TIMEOUT_CLKS = 8192,
    parameter int WIN          = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down,
    input  logic       low_sq,
    input  logic       high_sq,
    output logic       sig_cond,
    output logic [1:0] row_idx,
    output logic [1:0] col_idx
);

    localparam int CNT_W  = $clog2(TIMEOUT_CLKS + 1);
    localparam int SUM_W  = $clog2(WIN * TIMEOUT_CLKS + 1);
    localparam int FILL_W = $clog2(WIN + 1);

    logic [1:0]       sq_vec;
    logic [SUM_W-1:0] ch_sum    [2];
    logic [CNT_W-1:0] ch_period [2];
    logic [IDX_W-1:0] ch_idx    [2];
    logic [1:0]       ch_full;
    logic [1:0]       ch_upd;
    logic [1:0]       ch_tmo;
    logic [1:0]       ch_valid;

    assign sq_vec = {high_sq, low_sq};

    // One measurement-and-classification chain per band.
    for (genvar g = 0; g < 2; g++) begin : g_band
        tone_period_meter #(
            .TIMEOUT_CLKS (TIMEOUT_CLKS),
            .WIN          (WIN),
            .CNT_W        (CNT_W),
            .SUM_W        (SUM_W),
            .FILL_W       (FILL_W)
        ) u_meter (
            .clk         (clk),
            .rst_n       (rst_n),
            .pwr_down    (pwr_down),
            .sq_in       (sq_vec[g]),
            .win_sum     (ch_sum[g]),
            .win_full    (ch_full[g]),
            .upd_p       (ch_upd[g]),
            .tmo_p       (ch_tmo[g]),
            .last_period (ch_period[g])
        );

        tone_group_classifier #(
            .CLK_HZ (CLK_HZ),
            .GROUP  (g),
            .WIN    (WIN),
            .SUM_W  (SUM_W)
        ) u_class (
            .clk        (clk),
            .rst_n      (rst_n),
            .pwr_down   (pwr_down),
            .win_sum    (ch_sum[g]),
            .win_full   (ch_full[g]),
            .tone_valid (ch_valid[g]),
            .tone_idx   (ch_idx[g])
        );
    end

    assign sig_cond = &ch_valid;
    assign row_idx  = ch_idx[0];
    assign col_idx  = ch_idx[1];

endmodule

// File: rtl/dtmf_pair_detector_chk.sv
// Property checker for dtmf_pair_detector, attached by bind. It observes the
// per-band pulses from the meters against the classifier state and outputs.
module dtmf_pair_detector_chk #(
    parameter int TIMEOUT_CLKS = 8192,
    parameter int CNT_W        = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_down,
    input logic             sig_cond,
    input logic [1:0]       ch_full,
    input logic [1:0]       ch_upd,
    input logic [1:0]       ch_tmo,
    input logic [1:0]       ch_valid,
    input logic [1:0]       idx_lo,
    input logic [1:0]       idx_hi,
    input logic [CNT_W-1:0] per_lo,
    input logic [CNT_W-1:0] per_hi
);

    // R7: a cycle of power-down leaves the flag low.
    a_r7_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_down) |-> !sig_cond);

    // R5/R6: a timeout on either band removes the flag on the next cycle.
    a_r5_tmo_drops_flag: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
        (|ch_tmo) |=> !sig_cond);

    // R5: measured periods always stay below the timeout.
    a_r5_lo_period_bound: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
        ch_upd[0] |-> (per_lo < CNT_W'(TIMEOUT_CLKS)));
    a_r5_hi_period_bound: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
        ch_upd[1] |-> (per_hi < CNT_W'(TIMEOUT_CLKS)));

    // R2: a band turns valid only from a full window.
    a_r2_lo_full_window: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
        $rose(ch_valid[0]) |-> $past(ch_full[0]));
    a_r2_hi_full_window: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
        $rose(ch_valid[1]) |-> $past(ch_full[1]));

    // R9: without a new period or timeout, a valid band keeps its index.
    a_r9_lo_idx_steady: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
        ($past(ch_valid[0]) && !$past(ch_upd[0]) && !$past(ch_tmo[0])
         && !$past(pwr_down) && $past(rst_n)) |-> (ch_valid[0] && $stable(idx_lo)));
    a_r9_hi_idx_steady: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
        ($past(ch_valid[1]) && !$past(ch_upd[1]) && !$past(ch_tmo[1])
         && !$past(pwr_down) && $past(rst_n)) |-> (ch_valid[1] && $stable(idx_hi)));

endmodule

bind dtmf_pair_detector dtmf_pair_detector_chk #(
    .TIMEOUT_CLKS (TIMEOUT_CLKS),
    .CNT_W        (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .sig_cond (sig_cond),
    .ch_full  (ch_full),
    .ch_upd   (ch_upd),
    .ch_tmo   (ch_tmo),
    .ch_valid (ch_valid),
    .idx_lo   (ch_idx[0]),
    .idx_hi   (ch_idx[1]),
    .per_lo   (ch_period[0]),
    .per_hi   (ch_period[1])
);

// File: tb/dtmf_pair_detector_tb.sv
`timescale 1ns/1ps
module dtmf_pair_detector_tb;

    localparam int CLK_HZ = 357955;   // scaled counting rate keeps periods short
    localparam int TMO    = 800;
    localparam int WIN    = 4;
    localparam int SETTLE = (WIN + 4) * 540;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_down = 1'b0;
    logic       low_sq = 1'b0;
    logic       high_sq = 1'b0;
    logic       sig_cond;
    logic [1:0] row_idx;
    logic [1:0] col_idx;

    int vectors = 0;
    int miscompares = 0;
    int lp = 0;
    int hp = 0;

    always #10 clk = ~clk;

    dtmf_pair_detector #(
        .CLK_HZ       (CLK_HZ),
        .TIMEOUT_CLKS (TMO),
        .WIN          (WIN)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .low_sq   (low_sq),
        .high_sq  (high_sq),
        .sig_cond (sig_cond),
        .row_idx  (row_idx),
        .col_idx  (col_idx)
    );

    function automatic int freq(input int g, input int k);
        int lo [4] = '{697, 770, 852, 941};
        int hi [4] = '{1209, 1336, 1477, 1633};
        return (g == 0) ? lo[k] : hi[k];
    endfunction

    function automatic int nom(input int g, input int k);
        return (CLK_HZ + freq(g, k) / 2) / freq(g, k);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Low-band square-wave source; period 0 means silent.
    initial forever begin
        if (lp == 0) begin
            low_sq = 1'b0;
            @(negedge clk);
        end else begin
            automatic int p = lp;
            low_sq = 1'b1;
            repeat (p / 2) @(negedge clk);
            low_sq = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    end

    // High-band square-wave source.
    initial forever begin
        if (hp == 0) begin
            high_sq = 1'b0;
            @(negedge clk);
        end else begin
            automatic int p = hp;
            high_sq = 1'b1;
            repeat (p / 2) @(negedge clk);
            high_sq = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        repeat (195000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        summary();
    end

    // Cold-start acquisition of low tone 0 at period p.
    task automatic cold_low(input string req, input int p, input int exp);
        lp = 0;
        wait_clks(TMO + 600);
        lp = p;
        wait_clks(SETTLE);
        chk(req, int'(sig_cond), exp);
    endtask

    initial begin
        int n0, acc_min, acc_max, hold_max;
        wait_clks(5);
        // R8: reset state
        chk("R8 sig_cond", int'(sig_cond), 0);
        chk("R8 row_idx", int'(row_idx), 0);
        chk("R8 col_idx", int'(col_idx), 0);
        rst_n = 1'b1;

        // R6: a single tone is not a pair
        lp = nom(0, 2);
        wait_clks(SETTLE);
        chk("R6 single tone", int'(sig_cond), 0);

        // R1: sweep of all sixteen pairs at nominal periods
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                lp = nom(0, r);
                hp = nom(1, c);
                wait_clks(SETTLE);
                chk("R1 sig_cond", int'(sig_cond), 1);
                chk("R1 row_idx", int'(row_idx), r);
                chk("R1 col_idx", int'(col_idx), c);
            end
        end

        // R5/R6: high band stops, timeout removes the flag
        hp = 0;
        wait_clks(TMO + 600);
        chk("R5 timeout drop", int'(sig_cond), 0);
        hp = nom(1, 0);

        // R3: accept-band edges from cold, low tone 0
        n0       = nom(0, 0);
        acc_max  = (102 * n0) / 100;
        acc_min  = (98 * n0 + 99) / 100;
        hold_max = (1035 * n0) / 1000;
        cold_low("R3 accept upper edge", acc_max, 1);
        chk("R3 row at upper edge", int'(row_idx), 0);
        cold_low("R3 reject above", acc_max + 1, 0);
        cold_low("R3 accept lower edge", acc_min, 1);
        cold_low("R3 reject below", acc_min - 1, 0);

        // R4: hold band after locking at nominal
        cold_low("R4 lock nominal", n0, 1);
        lp = hold_max;
        wait_clks(SETTLE);
        chk("R4 hold edge valid", int'(sig_cond), 1);
        chk("R4 hold edge row", int'(row_idx), 0);
        lp = hold_max + 1;
        wait_clks(SETTLE);
        chk("R4 beyond hold", int'(sig_cond), 0);

        // R7/R2: power-down, then fresh acquisition
        lp = nom(0, 3);
        hp = nom(1, 2);
        wait_clks(SETTLE);
        chk("R7 locked before pd", int'(sig_cond), 1);
        pwr_down = 1'b1;
        wait_clks(50);
        chk("R7 pd forces low", int'(sig_cond), 0);
        pwr_down = 1'b0;
        wait_clks(2);
        chk("R7 no instant return", int'(sig_cond), 0);
        wait_clks(WIN * nom(1, 2) - 20);
        chk("R2 short of window", int'(sig_cond), 0);
        wait_clks(SETTLE);
        chk("R7 reacquired", int'(sig_cond), 1);
        chk("R7 row", int'(row_idx), 3);
        chk("R7 col", int'(col_idx), 2);

        // R9: steady pair keeps steady indices
        for (int i = 0; i < 5; i++) begin
            wait_clks(313);
            chk("R9 steady flag", int'(sig_cond), 1);
            chk("R9 steady row", int'(row_idx), 3);
            chk("R9 steady col", int'(col_idx), 2);
        end

        summary();
    end

endmodule